// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Status

This block receives asynchronous serial frames on a single input line. A free-running oversampling strobe, generated elsewhere at a fixed multiple of the bit rate, paces the receiver. A low level on the idle line starts a frame. The receiver confirms the start bit half a bit later and then takes each following bit as a two-of-three vote around the bit centre. The data bits arrive least significant bit first. An optional parity bit follows them, and then one stop bit.

A completed byte lands in a one-entry receive buffer. Parity, framing and overrun problems are kept as separate sticky status bits until software reads the status. If a byte completes while the previous byte is still unread, the new byte is dropped and the old one is kept. A power control holds every register in its reset state. A receive enable, which software raises after power, allows frames to start. The receiver treats the line level, not an edge, as the start condition. So enabling it while the line is already low begins a frame at once.

Top module: `async_rx_unit`

## Requirements
- R1: While `pwr_en` is low, the buffer, the full flag, all three status bits and both pulses are held at zero, and no frame is received.
- R2: Any low line level seen while powered and enabled starts a frame, including a level that was already low when `rx_en` rose. The start bit is checked again at tick OVS/2 of the bit. A high level there abandons the frame with no output.
- R3: Each data bit is the majority of the line samples at ticks OVS/2-1, OVS/2 and OVS/2+1 of its bit, counting the first tick after start detection as 1. Bits are assembled least significant first into `rx_buf`.
- R4: Parity modes on `par_mode` are: 00 no parity bit, 01 parity bit present but never checked, 10 odd (data plus parity holds an odd number of ones) and 11 even. A mismatch in odd or even mode sets `st_par`.
- R5: The parity mode is taken from `par_mode` only while `rx_en` is low. Changes made while `rx_en` is high have no effect on reception.
- R6: Exactly one stop bit is checked, by majority at its centre, and the frame ends at that sample. A low stop bit sets `st_frm`, and the data byte is still stored.
- R7: If a frame completes while `buf_full` is high and `buf_rd` is not asserted in that cycle, the new byte is discarded, `rx_buf` keeps the unread byte and `st_ovr` is set.
- R8: A stored byte raises `buf_full` and gives a one-cycle `rx_done` pulse in the cycle after the stop sample. `buf_rd` clears `buf_full`.
- R9: `rx_err` pulses for one cycle after any frame that ends with a parity, framing or overrun error.
- R10: `stat_rd` clears all three status bits. A new error in the same cycle wins over the clear.
- R11: Dropping `rx_en` during a frame abandons it with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power control; low holds all state cleared |
| rx_en | input | 1 | Receive enable |
| par_mode | input | 2 | Parity mode (00 none, 01 unchecked, 10 odd, 11 even) |
| baud_tick | input | 1 | Oversampling strobe, OVS per bit |
| rxd | input | 1 | Serial line, idle high |
| buf_rd | input | 1 | Buffer read strobe, clears full flag |
| stat_rd | input | 1 | Status read strobe, clears status bits |
| rx_buf | output | DATA_W | Receive buffer |
| buf_full | output | 1 | Unread byte present |
| st_par | output | 1 | Sticky parity error |
| st_frm | output | 1 | Sticky framing error |
| st_ovr | output | 1 | Sticky overrun error |
| rx_done | output | 1 | One-cycle pulse, byte stored |
| rx_err | output | 1 | One-cycle pulse, frame ended with an error |

## Verification
The bench builds the block with OVS=8, DATA_W=8 and a two-stage line synchroniser. A tick arrives every fourth clock, so every one of the 256 byte values fits in one run, each under a rotating parity mode and with a deliberately wrong parity bit on every third frame. The small oversampling factor also makes it cheap to place glitches on every tick position of a bit, inside and outside the three-sample vote window.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [1:0] {
    PM_NONE = 2'b00,
    PM_ZERO = 2'b01,
    PM_ODD  = 2'b10,
    PM_EVEN = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int unsigned MAX_DATA_W = 16;

  // two-of-three vote
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
  endfunction

  // high when the received parity bit disagrees with the selected mode
  function automatic logic parity_fail(input logic [MAX_DATA_W-1:0] d,
                                       input logic pbit,
                                       input par_mode_e m);
    logic odd_ones;
    odd_ones = (^d) ^ pbit;
    case (m)
      PM_ODD:  return !odd_ones;
      PM_EVEN: return odd_ones;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain_q <= 1'b1;
        else if (clr) chain_q <= 1'b1;
        else          chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain_q <= '1;
        else if (clr) chain_q <= '1;
        else          chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import async_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic rx_s,
  output logic mid_hit,
  output logic samp_hit,
  output logic bit_end,
  output logic maj_bit
);
  localparam int unsigned MID = OVS / 2;
  localparam int unsigned CW  = $clog2(OVS + 1);
  localparam logic [CW-1:0] K_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] K_MID = CW'(MID);
  localparam logic [CW-1:0] K_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] K_END = CW'(OVS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic [1:0]    win_q;
  logic          in_window;

  assign cnt_nx    = cnt_q + 1'b1;
  assign in_window = (cnt_nx == K_LO) || (cnt_nx == K_MID);

  assign mid_hit  = run && tick && (cnt_nx == K_MID);
  assign samp_hit = run && tick && (cnt_nx == K_HI);
  assign bit_end  = run && tick && (cnt_nx == K_END);
  assign maj_bit  = maj3({win_q, rx_s});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= 2'b11;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_nx == K_END) ? '0 : cnt_nx;
      if (in_window) win_q <= {win_q[0], rx_s};
    end
  end

  // R3: tick counter never leaves one bit period
  p_cnt_in_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < K_END);

  // R3: the vote strobe follows the mid strobe within the same bit
  p_samp_after_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    samp_hit |-> (cnt_q == K_MID));
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rx_s,
  input  par_mode_e         par_cfg,
  input  logic              mid_hit,
  input  logic              samp_hit,
  input  logic              bit_end,
  input  logic              maj_bit,
  output logic              run,
  output logic              frame_end,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_par_err,
  output logic              frame_frm_err
);
  localparam int unsigned IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  rx_state_e         st_q, st_d;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              pbit_q;
  logic              last_bit;
  logic              start_abort;

  assign last_bit    = (idx_q == LAST_IDX);
  assign start_abort = (st_q == ST_START) && mid_hit && rx_s;

  always_comb begin
    st_d = st_q;
    if (!active) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (!rx_s) st_d = ST_START;
        ST_START: begin
          if (start_abort)  st_d = ST_IDLE;
          else if (bit_end) st_d = ST_DATA;
        end
        ST_DATA:  if (bit_end && last_bit)
                    st_d = (par_cfg == PM_NONE) ? ST_STOP : ST_PAR;
        ST_PAR:   if (bit_end) st_d = ST_STOP;
        ST_STOP:  if (samp_hit) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_START)                 idx_q <= '0;
      else if (st_q == ST_DATA && bit_end)  idx_q <= idx_q + 1'b1;
      if (st_q == ST_DATA && samp_hit)
        sh_q <= (DATA_W > 1) ? {maj_bit, sh_q[DATA_W-1:1]} : DATA_W'(maj_bit);
      if (st_q == ST_PAR && samp_hit)       pbit_q <= maj_bit;
    end
  end

  assign run           = (st_q != ST_IDLE);
  assign frame_end     = active && (st_q == ST_STOP) && samp_hit;
  assign frame_data    = sh_q;
  assign frame_frm_err = !maj_bit;
  assign frame_par_err = parity_fail(MAX_DATA_W'(sh_q), pbit_q, par_cfg);

  // R2: a high start sample returns to idle
  p_start_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start_abort) |=> (st_q == ST_IDLE));

  // R11: losing enable leaves the frame
  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (st_q == ST_IDLE));

  // R6: the frame ends at the single stop sample
  p_single_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (st_q == ST_IDLE));
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              buf_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              st_par,
  output logic              st_frm,
  output logic              st_ovr,
  output logic              rx_done,
  output logic              rx_err
);
  logic ovr_hit;
  logic store_hit;
  logic any_err;

  assign ovr_hit   = frame_end && buf_full && !buf_rd;
  assign store_hit = frame_end && !ovr_hit;
  assign any_err   = frame_end && (par_err || frm_err || ovr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      buf_full <= 1'b0;
      st_par   <= 1'b0;
      st_frm   <= 1'b0;
      st_ovr   <= 1'b0;
      rx_done  <= 1'b0;
      rx_err   <= 1'b0;
    end else if (!pwr_en) begin
      rx_buf   <= '0;
      buf_full <= 1'b0;
      st_par   <= 1'b0;
      st_frm   <= 1'b0;
      st_ovr   <= 1'b0;
      rx_done  <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      if (store_hit)   rx_buf <= frame_data;
      if (store_hit)   buf_full <= 1'b1;
      else if (buf_rd) buf_full <= 1'b0;
      st_par  <= (frame_end && par_err) || (st_par && !stat_rd);
      st_frm  <= (frame_end && frm_err) || (st_frm && !stat_rd);
      st_ovr  <= ovr_hit || (st_ovr && !stat_rd);
      rx_done <= store_hit;
      rx_err  <= any_err;
    end
  end

  // R1: power low clears everything
  p_pwr_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (!buf_full && !st_par && !st_frm && !st_ovr && !rx_done && !rx_err));

  // R7: overrun keeps the unread byte
  p_ovr_keeps_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ovr_hit) |=> ($stable(rx_buf) && st_ovr && buf_full));

  // R8: done is a single-cycle pulse and comes with a full buffer
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  p_done_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> buf_full);

  // R9: error is a single-cycle pulse
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err);

  // R10: a status read with no new event empties the status
  p_rd_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frame_end) |=> (!st_par && !st_frm && !st_ovr));
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              rx_en,
  input  logic [1:0]        par_mode,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              buf_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              st_par,
  output logic              st_frm,
  output logic              st_ovr,
  output logic              rx_done,
  output logic              rx_err
);
  par_mode_e         par_cfg_q;
  logic              active;
  logic              rx_s;
  logic              run;
  logic              mid_hit, samp_hit, bit_end, maj_bit;
  logic              frame_end, frame_par_err, frame_frm_err;
  logic [DATA_W-1:0] frame_data;

  assign active = pwr_en && rx_en;

  // parity mode is only taken while reception is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_cfg_q <= PM_NONE;
    else if (!pwr_en) par_cfg_q <= PM_NONE;
    else if (!rx_en)  par_cfg_q <= par_mode_e'(par_mode);
  end

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst_n (rst_n),
    .clr (!pwr_en),
    .d   (rxd),
    .q   (rx_s)
  );

  rx_bit_timer #(.OVS(OVS)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (baud_tick),
    .rx_s     (rx_s),
    .mid_hit  (mid_hit),
    .samp_hit (samp_hit),
    .bit_end  (bit_end),
    .maj_bit  (maj_bit)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .rx_s          (rx_s),
    .par_cfg       (par_cfg_q),
    .mid_hit       (mid_hit),
    .samp_hit      (samp_hit),
    .bit_end       (bit_end),
    .maj_bit       (maj_bit),
    .run           (run),
    .frame_end     (frame_end),
    .frame_data    (frame_data),
    .frame_par_err (frame_par_err),
    .frame_frm_err (frame_frm_err)
  );

  rx_status_regs #(.DATA_W(DATA_W)) stat_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en     (pwr_en),
    .frame_end  (frame_end),
    .frame_data (frame_data),
    .par_err    (frame_par_err),
    .frm_err    (frame_frm_err),
    .buf_rd     (buf_rd),
    .stat_rd    (stat_rd),
    .rx_buf     (rx_buf),
    .buf_full   (buf_full),
    .st_par     (st_par),
    .st_frm     (st_frm),
    .st_ovr     (st_ovr),
    .rx_done    (rx_done),
    .rx_err     (rx_err)
  );

  // R5: the latched mode holds while reception is enabled
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && rx_en) |=> $stable(par_cfg_q));
endmodule

// File: tb/async_rx_unit_tb_top.sv
module async_rx_unit_tb_top;
  localparam int OVS = 8;
  localparam int DW  = 8;
  localparam int WD_CYCLES = 195000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_en = 1'b0;
  logic          rx_en = 1'b0;
  logic [1:0]    par_mode = 2'b00;
  logic          baud_tick = 1'b0;
  logic          rxd = 1'b1;
  logic          buf_rd = 1'b0;
  logic          stat_rd = 1'b0;
  logic [DW-1:0] rx_buf;
  logic          buf_full, st_par, st_frm, st_ovr, rx_done, rx_err;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  n_done  = 0;
  int  n_err   = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  async_rx_unit #(.DATA_W(DW), .OVS(OVS), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst_n (rst_n), .pwr_en (pwr_en), .rx_en (rx_en),
    .par_mode (par_mode), .baud_tick (baud_tick), .rxd (rxd),
    .buf_rd (buf_rd), .stat_rd (stat_rd), .rx_buf (rx_buf),
    .buf_full (buf_full), .st_par (st_par), .st_frm (st_frm),
    .st_ovr (st_ovr), .rx_done (rx_done), .rx_err (rx_err)
  );

  always @(negedge clk) begin
    if (rx_done) n_done++;
    if (rx_err)  n_err++;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one oversampling period: line value set, tick on the fourth clock
  task automatic period(input logic v);
    @(negedge clk); rxd = v; baud_tick = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk); baud_tick = 1'b1;
  endtask

  task automatic send_bit(input logic v, input logic [OVS-1:0] gm);
    for (int t = 0; t < OVS; t++) period(v ^ gm[t]);
  endtask

  function automatic logic exp_pbit(input logic [DW-1:0] d, input logic [1:0] m);
    case (m)
      2'b10:   return ~^d;
      2'b11:   return ^d;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_frame(input logic [DW-1:0] d, input logic [1:0] m,
                            input logic pflip, input logic stop_v,
                            input logic [DW-1:0] gbits, input logic [OVS-1:0] gm);
    send_bit(1'b0, '0);
    for (int b = 0; b < DW; b++) send_bit(d[b], gbits[b] ? gm : '0);
    if (m != 2'b00) send_bit(exp_pbit(d, m) ^ pflip, '0);
    send_bit(stop_v, '0);
    send_bit(1'b1, '0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); rx_en = 1'b0; par_mode = m; baud_tick = 1'b0;
    @(negedge clk); rx_en = 1'b1;
  endtask

  task automatic rd_buf();
    @(negedge clk); buf_rd = 1'b1; baud_tick = 1'b0;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1; baud_tick = 1'b0;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int d0, e0;
    logic exp_perr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "reset buf", rx_buf, 0);
    chk("R1", "reset flags", {buf_full, st_par, st_frm, st_ovr, rx_done, rx_err}, 0);

    @(negedge clk); pwr_en = 1'b1;
    set_mode(2'b00);

    // R3 R8 basic frame
    d0 = n_done;
    send_frame(8'hA5, 2'b00, 1'b0, 1'b1, '0, '0);
    chk("R3", "basic data", rx_buf, 8'hA5);
    chk("R8", "basic full", buf_full, 1);
    chk("R8", "basic done pulses", n_done - d0, 1);
    rd_buf();
    chk("R8", "full cleared by read", buf_full, 0);

    // sweep every byte value across parity modes
    for (int i = 0; i < 256; i++) begin
      logic [1:0] m;
      logic fl;
      m  = 2'(i % 4);
      fl = (i % 3 == 0);
      exp_perr = fl && m[1];
      set_mode(m);
      d0 = n_done; e0 = n_err;
      send_frame(8'(i), m, fl, 1'b1, '0, '0);
      chk("R3", "sweep data", rx_buf, 32'(i));
      chk("R8", "sweep done", n_done - d0, 1);
      chk("R4", "sweep parity flag", st_par, exp_perr);
      chk("R9", "sweep err pulse", n_err - e0, exp_perr);
      rd_stat();
      rd_buf();
      chk("R10", "sweep status cleared", {st_par, st_frm, st_ovr}, 0);
    end

    // R3 majority voting
    set_mode(2'b00);
    send_frame(8'h3C, 2'b00, 1'b0, 1'b1, 8'hFF, 8'b0000_1000);
    chk("R3", "glitch mid sample", rx_buf, 8'h3C); rd_buf();
    send_frame(8'h3C, 2'b00, 1'b0, 1'b1, 8'hFF, 8'b0000_0100);
    chk("R3", "glitch early sample", rx_buf, 8'h3C); rd_buf();
    send_frame(8'hC3, 2'b00, 1'b0, 1'b1, 8'hFF, 8'b0001_0000);
    chk("R3", "glitch late sample", rx_buf, 8'hC3); rd_buf();
    send_frame(8'h69, 2'b00, 1'b0, 1'b1, 8'hFF, 8'b1100_0011);
    chk("R3", "glitch outside window", rx_buf, 8'h69); rd_buf();
    send_frame(8'h00, 2'b00, 1'b0, 1'b1, 8'h01, 8'b0001_1000);
    chk("R3", "two samples flip bit0", rx_buf, 8'h01); rd_buf();

    // R2 false start aborts
    d0 = n_done; e0 = n_err;
    for (int t = 0; t < 3; t++) period(1'b0);
    send_bit(1'b1, '0);
    send_bit(1'b1, '0);
    chk("R2", "false start no done", n_done - d0, 0);
    chk("R2", "false start no err", n_err - e0, 0);
    chk("R2", "false start buf kept", {buf_full, rx_buf}, {1'b0, 8'h01});

    // R2 enable while line low starts reception
    @(negedge clk); rx_en = 1'b0; rxd = 1'b0; baud_tick = 1'b0;
    repeat (12) @(negedge clk);
    rx_en = 1'b1;
    d0 = n_done;
    send_frame(8'h9B, 2'b00, 1'b0, 1'b1, '0, '0);
    chk("R2", "enable on low line", rx_buf, 8'h9B);
    chk("R2", "enable on low done", n_done - d0, 1);
    rd_buf();

    // R6 R9 R10 framing error
    d0 = n_done; e0 = n_err;
    send_frame(8'h5A, 2'b00, 1'b0, 1'b0, '0, '0);
    chk("R6", "framing flag", {st_par, st_frm, st_ovr}, 3'b010);
    chk("R6", "framing data stored", rx_buf, 8'h5A);
    chk("R9", "framing err pulse", n_err - e0, 1);
    rd_stat();
    chk("R10", "framing cleared", st_frm, 0);
    rd_buf();

    // R7 overrun
    d0 = n_done; e0 = n_err;
    send_frame(8'h11, 2'b00, 1'b0, 1'b1, '0, '0);
    send_frame(8'h22, 2'b00, 1'b0, 1'b1, '0, '0);
    chk("R7", "overrun keeps old", rx_buf, 8'h11);
    chk("R7", "overrun flag", {st_par, st_frm, st_ovr}, 3'b001);
    chk("R7", "overrun single done", n_done - d0, 1);
    chk("R9", "overrun err pulse", n_err - e0, 1);
    rd_buf();
    chk("R8", "overrun read clears full", buf_full, 0);
    rd_stat();
    chk("R10", "overrun cleared", st_ovr, 0);

    // R5 mode changes ignored while enabled
    set_mode(2'b11);
    @(negedge clk); par_mode = 2'b00;
    e0 = n_err;
    send_frame(8'h37, 2'b11, 1'b1, 1'b1, '0, '0);
    chk("R5", "latched even mode checked", st_par, 1);
    chk("R5", "latched mode data", rx_buf, 8'h37);
    rd_stat(); rd_buf();

    // R11 disable mid-frame
    set_mode(2'b00);
    d0 = n_done; e0 = n_err;
    send_bit(1'b0, '0);
    send_bit(1'b1, '0);
    send_bit(1'b0, '0);
    @(negedge clk); rx_en = 1'b0;
    for (int b = 0; b < 6; b++) send_bit(1'b0, '0);
    send_bit(1'b1, '0);
    chk("R11", "aborted frame no done", n_done - d0, 0);
    chk("R11", "aborted frame state", {buf_full, st_par, st_frm, st_ovr}, 0);
    @(negedge clk); rx_en = 1'b1;
    send_frame(8'hE4, 2'b00, 1'b0, 1'b1, '0, '0);
    chk("R11", "recovery frame", rx_buf, 8'hE4);

    // R1 power off clears, and blocks reception
    send_frame(8'h77, 2'b00, 1'b0, 1'b0, '0, '0);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); pwr_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "power off buf", rx_buf, 0);
    chk("R1", "power off flags", {buf_full, st_par, st_frm, st_ovr}, 0);
    d0 = n_done;
    @(negedge clk); rx_en = 1'b1;
    send_frame(8'h42, 2'b00, 1'b0, 1'b1, '0, '0);
    chk("R1", "no reception when off", {n_done - d0, 24'(0), rx_buf}, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule